// File: doc/BRIEF.md
# Scrubbing Shared Staging Buffer Arbiter

This block sits between several hardware threads and one staging buffer outside the cores. Every sensitive read passes through that buffer: random numbers, seed values and key derivations. A thread raises a request and holds it until its data comes back. With the request it gives the read kind, a flag that says whether the thread runs in enclave mode, and, through its own control register, whether it has opted out of protection.

A protected read owns the buffer alone. From the cycle it is granted until the buffer has been wiped, every other thread sees its off-core stall line raised. When the data has been returned, a sequencer writes zero into every buffer word, one word per cycle. Only then can another thread be granted. A thread that has opted out, issuing a random or seed read outside enclave mode, is served with the bare two-cycle grant: no wipe and no stall. Pending requests are served in rotating order by thread number.

A second read port lets the buffer contents be observed, as another thread would see them, one cycle after an address is presented.

Top module: `sbuf_arbiter`

## Requirements
- R1: After synchronous reset no grant, data-valid or stall output is high, and every thread's opt-out bit is 0, so all reads are protected.
- R2: The read kind is encoded as 0 = random, 1 = seed, 2 = key derivation; code 3 is treated like a key derivation. A request seen while the arbiter is free is granted in the next cycle. The grant lasts two cycles. In the second cycle a one-cycle data-valid pulse carries the value that was on `src_data_i` during the first grant cycle.
- R3: At most one thread holds a grant in any cycle.
- R4: Among pending requests, the first thread after the most recent owner, counting upward with wraparound, is served next. After reset thread 0 has the highest priority.
- R5: During a protected read, every thread other than the owner has its stall output high. The stall lasts from the first grant cycle through the last wipe cycle. The owner is never stalled.
- R6: After a protected read's data-valid cycle, the next DEPTH cycles write zero to buffer words 0 through DEPTH-1 in that order.
- R7: After a protected read, no grant is given during the wipe. If a request is pending, the next grant starts exactly DEPTH+1 cycles after the data-valid cycle.
- R8: A write with `cfg_addr_i` equal to 0x123 sets bit 0 of the addressed thread's control register, which is its opt-out bit. A write to any other address changes nothing.
- R9: A thread with its opt-out bit set, issuing a random or seed read outside enclave mode, gets no wipe and raises no stall. Its next grant may start two cycles after its data-valid cycle.
- R10: One thread's opt-out bit has no effect on how other threads' reads are handled.
- R11: A read issued in enclave mode, and every key-derivation read, is protected whatever the opt-out bit says.
- R12: `peek_data_o` shows the buffer word at `peek_addr_i` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | N_THR | Per-thread request, held until its data-valid pulse |
| req_kind_i | input | 2*N_THR | Per-thread read kind, two bits per thread |
| req_encl_i | input | N_THR | Per-thread enclave-mode flag |
| src_data_i | input | DW | Data from the sensitive source, captured in the first grant cycle |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_tid_i | input | TW | Thread addressed by the write |
| cfg_addr_i | input | CFG_AW | Register address of the write |
| cfg_wdata_i | input | 1 | Value written to bit 0 (opt-out) |
| peek_addr_i | input | AW | Buffer word to observe |
| grant_o | output | N_THR | One-hot buffer ownership |
| rd_valid_o | output | N_THR | One-cycle data-valid pulse to the owner |
| rd_data_o | output | DW | Returned read data |
| offcore_stall_o | output | N_THR | Per-thread off-core access hold |
| peek_data_o | output | DW | Buffer word at the observed address |

## Verification
The bench releases all four threads in the same cycle. A wrong rotation pointer would serve them out of order or starve one, and a sequencer that started the next grant early would overlap a wipe and break the DEPTH+1 gap. It sets the opt-out bit on one thread and then issues enclave and key-derivation reads from that thread, which catches a design that lets the bit override those cases or leak onto neighbours. It also writes to an address one above the control register and checks that nothing changes. After each wipe it reads every buffer word back. A sequencer that skipped the last word or wrote a non-zero pattern would leave secret data in place, and a registered read with the wrong latency would show up as peek mismatches on every cycle.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  // Read kinds presented by a requesting thread
  typedef enum logic [1:0] {
    RD_RAND = 2'd0,
    RD_SEED = 2'd1,
    RD_KEY  = 2'd2,
    RD_RSVD = 2'd3
  } rd_kind_e;

  // Buffer sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DLVR  = 2'd2,
    ST_SCRUB = 2'd3
  } sbuf_st_e;

endpackage

// File: rtl/sbuf_ctrl_regs.sv
module sbuf_ctrl_regs #(
  parameter int N_THR  = 4,
  parameter int TW     = 2,
  parameter int CFG_AW = 12,
  parameter logic [CFG_AW-1:0] CFG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [TW-1:0]     tid,
  input  logic [CFG_AW-1:0] addr,
  input  logic              wdata,
  output logic [N_THR-1:0]  optout
);

  logic hit;
  assign hit = we && (addr == CFG_ADDR);

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) begin
        optout[g] <= 1'b0;
      end else if (hit && (tid == TW'(g))) begin
        optout[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/sbuf_rr_pick.sv
module sbuf_rr_pick #(
  parameter int N_THR = 4,
  parameter int TW    = 2
) (
  input  logic [N_THR-1:0] req,
  input  logic [TW-1:0]    last,
  output logic             any,
  output logic [TW-1:0]    pick
);

  always_comb begin
    any  = 1'b0;
    pick = last;
    for (int k = 1; k <= N_THR; k++) begin
      int unsigned idx;
      idx = (int'(last) + k) % N_THR;
      if (!any && req[idx]) begin
        any  = 1'b1;
        pick = TW'(idx);
      end
    end
  end

endmodule

// File: rtl/sbuf_mem.sv
module sbuf_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sbuf_arbiter.sv
module sbuf_arbiter
  import sbuf_pkg::*;
#(
  parameter int N_THR  = 4,
  parameter int DEPTH  = 8,
  parameter int DW     = 32,
  parameter int CFG_AW = 12,
  parameter logic [CFG_AW-1:0] CFG_ADDR = CFG_AW'(12'h123),
  localparam int TW = (N_THR > 1) ? $clog2(N_THR) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_THR-1:0]     req_valid_i,
  input  logic [2*N_THR-1:0]   req_kind_i,
  input  logic [N_THR-1:0]     req_encl_i,
  input  logic [DW-1:0]        src_data_i,
  input  logic                 cfg_we_i,
  input  logic [TW-1:0]        cfg_tid_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic                 cfg_wdata_i,
  input  logic [AW-1:0]        peek_addr_i,
  output logic [N_THR-1:0]     grant_o,
  output logic [N_THR-1:0]     rd_valid_o,
  output logic [DW-1:0]        rd_data_o,
  output logic [N_THR-1:0]     offcore_stall_o,
  output logic [DW-1:0]        peek_data_o
);

  sbuf_st_e         st_q, st_n;
  logic [TW-1:0]    own_q, own_n, last_q;
  logic             mit_q, mit_n;
  logic [AW-1:0]    scr_q;
  logic [DW-1:0]    data_q;
  logic [N_THR-1:0] optout;
  logic             any;
  logic [TW-1:0]    pick;
  logic [1:0]       pick_kind;
  logic             pick_bypass;
  logic             pick_mit;
  logic             scr_last;
  logic             start;
  logic [N_THR-1:0] sel_n;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr;
  logic [DW-1:0]    mem_wdata;
  logic [N_THR-1:0] grant_q, rdv_q, stall_q;

  sbuf_ctrl_regs #(
    .N_THR   (N_THR),
    .TW      (TW),
    .CFG_AW  (CFG_AW),
    .CFG_ADDR(CFG_ADDR)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we_i),
    .tid   (cfg_tid_i),
    .addr  (cfg_addr_i),
    .wdata (cfg_wdata_i),
    .optout(optout)
  );

  sbuf_rr_pick #(
    .N_THR(N_THR),
    .TW   (TW)
  ) u_rr (
    .req (req_valid_i),
    .last(last_q),
    .any (any),
    .pick(pick)
  );

  // Protection is skipped only for an opted-out random/seed read outside enclave mode
  assign pick_kind   = req_kind_i[2*pick +: 2];
  assign pick_bypass = ((pick_kind == RD_RAND) || (pick_kind == RD_SEED))
                       && !req_encl_i[pick] && optout[pick];
  assign pick_mit    = !pick_bypass;

  assign scr_last = (scr_q == AW'(DEPTH-1));
  assign start    = any && ((st_q == ST_IDLE) || ((st_q == ST_SCRUB) && scr_last));

  always_comb begin
    st_n  = st_q;
    own_n = own_q;
    mit_n = mit_q;
    case (st_q)
      ST_FILL:  st_n = ST_DLVR;
      ST_DLVR:  st_n = mit_q ? ST_SCRUB : ST_IDLE;
      ST_SCRUB: if (scr_last) st_n = ST_IDLE;
      default:  ;
    endcase
    if (start) begin
      st_n  = ST_FILL;
      own_n = pick;
      mit_n = pick_mit;
    end
  end

  assign sel_n = N_THR'(1) << own_n;

  // Buffer write port: capture in the first grant cycle, zero fill while wiping
  assign mem_we    = (st_q == ST_FILL) || (st_q == ST_SCRUB);
  assign mem_waddr = (st_q == ST_FILL) ? '0 : scr_q;
  assign mem_wdata = (st_q == ST_FILL) ? src_data_i : '0;

  sbuf_mem #(
    .DEPTH(DEPTH),
    .DW   (DW),
    .AW   (AW)
  ) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(peek_addr_i),
    .rdata(peek_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      own_q   <= '0;
      mit_q   <= 1'b0;
      last_q  <= TW'(N_THR-1);
      scr_q   <= '0;
      data_q  <= '0;
      grant_q <= '0;
      rdv_q   <= '0;
      stall_q <= '0;
    end else begin
      st_q  <= st_n;
      own_q <= own_n;
      mit_q <= mit_n;
      if (start) begin
        last_q <= pick;
      end
      if (st_q == ST_FILL) begin
        data_q <= src_data_i;
      end
      if (st_q == ST_DLVR) begin
        scr_q <= '0;
      end else if (st_q == ST_SCRUB) begin
        scr_q <= scr_q + 1'b1;
      end
      grant_q <= ((st_n == ST_FILL) || (st_n == ST_DLVR)) ? sel_n : '0;
      rdv_q   <= (st_n == ST_DLVR) ? sel_n : '0;
      stall_q <= ((st_n != ST_IDLE) && mit_n) ? ~sel_n : '0;
    end
  end

  assign grant_o         = grant_q;
  assign rd_valid_o      = rdv_q;
  assign rd_data_o       = data_q;
  assign offcore_stall_o = stall_q;

endmodule

// File: rtl/sbuf_arbiter_chk.sv
module sbuf_arbiter_chk #(
  parameter int N_THR = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_THR-1:0] grant,
  input logic [N_THR-1:0] rd_valid,
  input logic [N_THR-1:0] stall
);

  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
    end else if ((rd_valid != '0) && (stall != '0)) begin
      hold_cnt <= CW'(DEPTH);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R2
  rdv_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid & ~grant) == '0);

  // R2
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid != '0) |=> (rd_valid == '0));

  // R5
  owner_free_chk: assert property (@(posedge clk) disable iff (rst)
    (stall & grant) == '0);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_valid != '0) && (stall != '0)) |=> $stable(stall));

  // R7
  scrub_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt != '0) |-> (grant == '0));

endmodule

bind sbuf_arbiter sbuf_arbiter_chk #(
  .N_THR(N_THR),
  .DEPTH(DEPTH)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .grant   (grant_o),
  .rd_valid(rd_valid_o),
  .stall   (offcore_stall_o)
);

// File: tb/test_sbuf_arbiter.sv
module test_sbuf_arbiter;

  localparam int N   = 4;
  localparam int D   = 8;
  localparam int DW  = 32;
  localparam int CAW = 12;
  localparam int TW  = 2;
  localparam int AW  = 3;
  localparam int WDOG = 60000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0]   req_valid = '0;
  logic [2*N-1:0] req_kind  = '0;
  logic [N-1:0]   req_encl  = '0;
  logic [DW-1:0]  src_data  = '0;
  logic           cfg_we    = 1'b0;
  logic [TW-1:0]  cfg_tid   = '0;
  logic [CAW-1:0] cfg_addr  = '0;
  logic           cfg_wdata = 1'b0;
  logic [AW-1:0]  peek_addr = '0;
  logic [N-1:0]   grant, rdv, stall;
  logic [DW-1:0]  rd_data, peek_data;

  sbuf_arbiter i_sbuf_arbiter (
    .clk            (clk),
    .rst            (rst),
    .req_valid_i    (req_valid),
    .req_kind_i     (req_kind),
    .req_encl_i     (req_encl),
    .src_data_i     (src_data),
    .cfg_we_i       (cfg_we),
    .cfg_tid_i      (cfg_tid),
    .cfg_addr_i     (cfg_addr),
    .cfg_wdata_i    (cfg_wdata),
    .peek_addr_i    (peek_addr),
    .grant_o        (grant),
    .rd_valid_o     (rdv),
    .rd_data_o      (rd_data),
    .offcore_stall_o(stall),
    .peek_data_o    (peek_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Behavioural reference state
  int           m_ph, m_cnt, m_own, m_last;
  bit           m_mit;
  bit           m_dis [N];
  logic [DW-1:0] m_mem [D];
  bit           m_known [D];
  logic [DW-1:0] m_data;
  logic [N-1:0] e_grant, e_rdv, e_stall;
  logic [DW-1:0] e_peek;
  bit           e_peek_ok;
  bit           peek_auto = 1'b1;

  // Event logs
  int ord_q[$];
  int stl_q[$];
  int rdv_cyc_q[$];
  int gnt_cyc_q[$];
  logic [N-1:0] prev_grant = '0;
  int issue_cyc;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic final_report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < D; k++) m_known[k] = 1'b0;
  end

  // Reference model advances on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      errors++;
      $display("FAIL R2 watchdog actual %0d expected below %0d", cyc, WDOG);
      final_report();
    end
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_own = 0; m_mit = 1'b0; m_last = N - 1;
      for (int k = 0; k < N; k++) m_dis[k] = 1'b0;
      e_grant = '0; e_rdv = '0; e_stall = '0; e_peek_ok = 1'b0;
    end else begin
      bit st;
      int p;
      bit pm;
      e_peek_ok = m_known[peek_addr];
      e_peek    = m_mem[peek_addr];
      st = 1'b0; p = 0; pm = 1'b1;
      if (req_valid != '0 && (m_ph == 0 || (m_ph == 3 && m_cnt == D - 1))) begin
        st = 1'b1;
        for (int k = N; k >= 1; k--) begin
          int idx;
          idx = (m_last + k) % N;
          if (req_valid[idx]) p = idx;
        end
        pm = !((req_kind[2*p +: 2] < 2) && !req_encl[p] && m_dis[p]);
      end
      case (m_ph)
        1: begin
          m_mem[0] = src_data; m_known[0] = 1'b1; m_data = src_data; m_ph = 2;
        end
        2: begin
          m_ph = m_mit ? 3 : 0; m_cnt = 0;
        end
        3: begin
          m_mem[m_cnt] = '0; m_known[m_cnt] = 1'b1;
          if (m_cnt == D - 1) m_ph = 0; else m_cnt++;
        end
        default: ;
      endcase
      if (st) begin
        m_ph = 1; m_own = p; m_mit = pm; m_last = p;
      end
      if (cfg_we && cfg_addr == 12'h123) m_dis[cfg_tid] = cfg_wdata;
      e_grant = (m_ph == 1 || m_ph == 2) ? N'(1 << m_own) : '0;
      e_rdv   = (m_ph == 2) ? N'(1 << m_own) : '0;
      e_stall = (m_ph != 0 && m_mit) ? (~N'(1 << m_own)) : '0;
    end
  end

  // Compare and record away from the active edge
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      chk("R3 grant", 64'(grant), 64'(e_grant));
      chk("R2 rd_valid", 64'(rdv), 64'(e_rdv));
      chk("R5 stall", 64'(stall), 64'(e_stall));
      if (e_rdv != '0) chk("R2 rd_data", 64'(rd_data), 64'(m_data));
      if (e_peek_ok) chk("R12 peek", 64'(peek_data), 64'(e_peek));
      if (grant != '0 && prev_grant == '0) gnt_cyc_q.push_back(cyc);
      prev_grant = grant;
      for (int i = 0; i < N; i++) begin
        if (rdv[i]) begin
          ord_q.push_back(i);
          stl_q.push_back(stall != '0 ? 1 : 0);
          rdv_cyc_q.push_back(cyc);
          req_valid[i] = 1'b0;
        end
      end
    end
    src_data = 32'hC0DE0000 ^ DW'(cyc * 32'h9E37);
    if (peek_auto) peek_addr = AW'(cyc % D);
  end

  task automatic clear_logs();
    ord_q.delete(); stl_q.delete(); rdv_cyc_q.delete(); gnt_cyc_q.delete();
  endtask

  task automatic issue(int t, int kind, bit encl);
    req_kind[2*t +: 2] = kind[1:0];
    req_encl[t] = encl;
    req_valid[t] = 1'b1;
    issue_cyc = cyc;
  endtask

  task automatic cfg_write(int t, int addr, bit val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tid = TW'(t); cfg_addr = CAW'(addr); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (req_valid != '0);
    repeat (D + 4) @(negedge clk);
  endtask

  task automatic single(int t, int kind, bit encl, int exp_stall, string tag);
    clear_logs();
    @(negedge clk);
    issue(t, kind, encl);
    wait_idle();
    chk({tag, " served once"}, 64'(ord_q.size()), 64'd1);
    if (stl_q.size() > 0) chk({tag, " stall"}, 64'(stl_q[0]), 64'(exp_stall));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk("R1 grant", 64'(grant), 64'd0);
    chk("R1 rd_valid", 64'(rdv), 64'd0);
    chk("R1 stall", 64'(stall), 64'd0);

    // R1 R5 R6: default-protected random read, then wipe check
    clear_logs();
    @(negedge clk);
    issue(0, 0, 1'b0);
    wait_idle();
    chk("R1 protected by default", 64'(stl_q.size() > 0 ? stl_q[0] : 0), 64'd1);
    if (gnt_cyc_q.size() > 0 && rdv_cyc_q.size() > 0) begin
      chk("R2 grant latency", 64'(gnt_cyc_q[0]), 64'(issue_cyc + 1));
      chk("R2 data-valid cycle", 64'(rdv_cyc_q[0]), 64'(issue_cyc + 2));
    end
    peek_auto = 1'b0;
    peek_addr = '0;
    for (int a = 0; a < D; a++) begin
      @(negedge clk);
      chk("R6 scrubbed word", 64'(peek_data), 64'd0);
      peek_addr = AW'(a + 1);
    end
    peek_auto = 1'b1;

    // R8 R9 R10: opt-out on thread 1 only
    cfg_write(1, 12'h123, 1'b1);
    single(1, 0, 1'b0, 0, "R9 random opted out");
    single(1, 1, 1'b0, 0, "R9 seed opted out");
    single(0, 0, 1'b0, 1, "R10 neighbour still protected");

    // R8: write to a different address is ignored
    cfg_write(2, 12'h124, 1'b1);
    single(2, 0, 1'b0, 1, "R8 other address ignored");

    // R11: enclave and key reads override opt-out
    single(1, 0, 1'b1, 1, "R11 enclave random");
    single(1, 2, 1'b0, 1, "R11 key derivation");
    single(1, 3, 1'b0, 1, "R2 reserved kind protected");

    // R4 R7: all threads at once, last owner was thread 1
    clear_logs();
    @(negedge clk);
    for (int t = 0; t < N; t++) issue(t, 0, 1'b0);
    wait_idle();
    chk("R4 count", 64'(ord_q.size()), 64'd4);
    if (ord_q.size() == 4) begin
      chk("R4 order first", 64'(ord_q[0]), 64'd2);
      chk("R4 order second", 64'(ord_q[1]), 64'd3);
      chk("R4 order third", 64'(ord_q[2]), 64'd0);
      chk("R4 order fourth", 64'(ord_q[3]), 64'd1);
      chk("R9 opted-out in burst", 64'(stl_q[3]), 64'd0);
    end
    if (gnt_cyc_q.size() == 4 && rdv_cyc_q.size() == 4) begin
      chk("R7 gap after wipe", 64'(gnt_cyc_q[1]), 64'(rdv_cyc_q[0] + D + 1));
      chk("R7 gap before opted-out", 64'(gnt_cyc_q[3]), 64'(rdv_cyc_q[2] + D + 1));
    end

    // R9: back-to-back opted-out reads carry no wipe latency
    cfg_write(3, 12'h123, 1'b1);
    clear_logs();
    @(negedge clk);
    issue(3, 1, 1'b0);
    issue(1, 0, 1'b0);
    wait_idle();
    if (ord_q.size() == 2 && gnt_cyc_q.size() == 2) begin
      chk("R9 order", 64'(ord_q[0]), 64'd3);
      chk("R9 short gap", 64'(gnt_cyc_q[1]), 64'(rdv_cyc_q[0] + 2));
      chk("R9 no stall", 64'(stl_q[0] | stl_q[1]), 64'd0);
    end else begin
      chk("R9 served twice", 64'(ord_q.size()), 64'd2);
    end

    // R8: clearing the bit restores protection
    cfg_write(1, 12'h123, 1'b0);
    single(1, 0, 1'b0, 1, "R8 re-enabled");

    final_report();
  end

endmodule